// File: doc/BRIEF.md
# Transmit Checksum Inserter

This block sits in a transmit byte stream. It computes a 16-bit ones'-complement checksum over the tail of each frame and writes the result back into that frame. Each frame is preceded by a short control record on a separate 32-bit stream. The record says whether insertion is wanted, where summing begins, where the result goes, and what seed value to add to the sum.

The block stores the whole frame in an internal buffer and sums the bytes as they arrive. After the final byte it checks the frame length. It then folds and complements the sum and replays the frame downstream, with the two result bytes placed most significant first. Frames sent while the transmitter is off are thrown away. Frames that overflow the buffer are dropped and reported. Frames in the length band just above a standard frame are dropped unless oversize or tagged frames are allowed. Every frame that is sent raises a one-cycle done pulse and adds its length to a 64-bit byte total.

Top module: `tx_csum_insert`

## Requirements
- R1: After reset `out_valid`, `tx_done`, `ovf_err` and `ctl_err` are 0, `ctl_ready` is 1, `byte_count` is 0, and `in_ready` is 0 while `tx_en` is 1.
- R2: A control record is taken only when it has exactly five 32-bit words, with `ctl_last` on the fifth. A shorter or longer record pulses `ctl_err` and is discarded. While a record is held, `ctl_ready` is 0. When `tx_en` is 1, frame bytes are accepted only while a record is held. The held record is released when its frame is sent or dropped.
- R3: The sum covers frame bytes from the start offset (word 1 bits 31:16) through the last byte. A byte at an even distance from the start offset is the high byte of a 16-bit term, and a byte at an odd distance is the low byte. A missing final low byte counts as zero.
- R4: The seed (word 2 bits 15:0) is added to the sum. The total is folded to 16 bits with end-around carry and then bit-inverted, so a folded value of 0xFFFF yields 0x0000.
- R5: The result is written with its high byte at the write offset (word 1 bits 15:0) and its low byte at the next position. Each of these two bytes is written only if its position lies inside the frame. Every other byte leaves the block unchanged and in order.
- R6: When word 0 bit 0 is 0, the frame is forwarded byte-for-byte unchanged.
- R7: While `tx_en` is 0, `in_ready` is 1 in the collecting phase and every accepted byte is discarded. A held record stays held.
- R8: A frame longer than `BUF_BYTES` is not forwarded and pulses `ovf_err`. A frame of exactly `BUF_BYTES` is forwarded.
- R9: With `jumbo_en` and `vlan_en` both 0, a frame of 1519 to 1522 bytes is dropped silently. If either of them is 1, the frame is forwarded. Frames of 1518 bytes or fewer are always forwarded.
- R10: `tx_done` pulses for one cycle in the cycle after the last output byte is accepted. In that same cycle `byte_count` has grown by the frame length, and it does not change at any other time.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable; bytes are discarded when 0 |
| jumbo_en | input | 1 | Allow frames above the standard length |
| vlan_en | input | 1 | Allow tagged-frame lengths up to 1522 |
| ctl_valid | input | 1 | Control word valid |
| ctl_data | input | 32 | Control word |
| ctl_last | input | 1 | Last word of the control record |
| ctl_ready | output | 1 | Control word accepted |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Last byte of frame |
| in_ready | output | 1 | Frame byte accepted |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Last output byte of frame |
| out_ready | input | 1 | Downstream accepts byte |
| tx_done | output | 1 | One-cycle pulse per forwarded frame |
| ovf_err | output | 1 | One-cycle pulse when an oversize frame is dropped |
| ctl_err | output | 1 | One-cycle pulse on a malformed control record |
| byte_count | output | CNT_W | Total bytes forwarded |

## Verification
The hardest case to reach from the ports is a frame that fills the buffer to its exact capacity, or passes it by one byte. Both cases must be sent byte by byte with a record held. The overflow frame must leave no trace except the error pulse and the released record. The stimulus sends a 2048-byte frame and then a 2049-byte frame, and confirms afterwards that a short frame still comes out intact. The length-band drop and the disabled-transmitter discard are reached in the same way. Random frame lengths, offsets past the frame end and stalls on `out_ready` cover the odd-parity and out-of-frame insertion positions.

// File: rtl/ckins_pkg.sv
package ckins_pkg;
  localparam int HDR_WORDS = 5;
  localparam int STD_MAX   = 1518;
  localparam int TAG_MAX   = 1522;

  typedef struct packed {
    logic        ins_en;
    logic [15:0] start_off;
    logic [15:0] wr_off;
    logic [15:0] seed;
  } hdr_t;

  typedef enum logic [1:0] {ST_FILL, ST_CHK, ST_DRAIN} st_t;

  // Add one byte into the running sum as the high or low half of a term.
  function automatic logic [31:0] sum_byte(logic [31:0] acc, logic [7:0] b, logic hi);
    return acc + (hi ? {16'd0, b, 8'd0} : {24'd0, b});
  endfunction

  // Add seed, fold twice with end-around carry, invert.
  function automatic logic [15:0] fold_cpl(logic [31:0] acc, logic [15:0] seed);
    logic [31:0] t;
    t = acc + {16'd0, seed};
    t = {16'd0, t[15:0]} + {16'd0, t[31:16]};
    t = {16'd0, t[15:0]} + {16'd0, t[31:16]};
    return ~t[15:0];
  endfunction
endpackage

// File: rtl/ckins_hdr.sv
module ckins_hdr
  import ckins_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_valid,
  input  logic [31:0] ctl_data,
  input  logic        ctl_last,
  output logic        ctl_ready,
  input  logic        release_i,
  output hdr_t        hdr_o,
  output logic        hdr_valid_o,
  output logic        err_o
);
  localparam int IW = $clog2(HDR_WORDS + 1);

  logic [IW-1:0] idx;
  hdr_t          cap;
  logic          valid_q;
  logic          err_q;

  assign ctl_ready   = !valid_q;
  assign hdr_o       = cap;
  assign hdr_valid_o = valid_q;
  assign err_o       = err_q;

  wire take = ctl_valid && !valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx     <= '0;
      cap     <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (release_i) valid_q <= 1'b0;
      if (take) begin
        if (idx == IW'(0)) cap.ins_en <= ctl_data[0];
        if (idx == IW'(1)) begin
          cap.start_off <= ctl_data[31:16];
          cap.wr_off    <= ctl_data[15:0];
        end
        if (idx == IW'(2)) cap.seed <= ctl_data[15:0];
        if (ctl_last) begin
          idx <= '0;
          if (idx == IW'(HDR_WORDS - 1)) valid_q <= 1'b1;
          else                           err_q   <= 1'b1;
        end else if (idx != IW'(HDR_WORDS)) begin
          idx <= idx + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ckins_sum.sv
module ckins_sum
  import ckins_pkg::*;
#(
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add_en,
  input  logic [LW-1:0] pos,
  input  logic [7:0]    data,
  input  logic [15:0]   start_off,
  input  logic [15:0]   seed,
  output logic [15:0]   csum_o
);
  logic [31:0] acc;

  wire in_range = 17'(pos) >= {1'b0, start_off};
  wire hi_half  = (pos[0] == start_off[0]);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)            acc <= '0;
    else if (add_en && in_range)  acc <= sum_byte(acc, data, hi_half);
  end

  assign csum_o = fold_cpl(acc, seed);
endmodule

// File: rtl/ckins_store.sv
module ckins_store #(
  parameter int DEPTH = 2048,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tx_csum_insert.sv
module tx_csum_insert
  import ckins_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int CNT_W     = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             jumbo_en,
  input  logic             vlan_en,
  input  logic             ctl_valid,
  input  logic [31:0]      ctl_data,
  input  logic             ctl_last,
  output logic             ctl_ready,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  input  logic             out_ready,
  output logic             tx_done,
  output logic             ovf_err,
  output logic             ctl_err,
  output logic [CNT_W-1:0] byte_count
);
  localparam int LW = $clog2(BUF_BYTES + 1);
  localparam int AW = $clog2(BUF_BYTES);

  st_t           st;
  hdr_t          hdr;
  logic          hdr_valid;
  logic [LW-1:0] len;
  logic [LW-1:0] rd;
  logic          ovf;
  logic [15:0]   csum_q;
  logic [15:0]   csum_now;
  logic [7:0]    mem_q;
  logic          done_q;
  logic          ovf_q;
  logic [CNT_W-1:0] cnt_q;

  // Named internal events
  wire in_fire    = in_valid && in_ready;
  wire byte_store = in_fire && tx_en;
  wire room       = len < LW'(BUF_BYTES);
  wire frame_end  = byte_store && in_last;
  wire band_drop  = !jumbo_en && !vlan_en &&
                    32'(len) >= 32'(STD_MAX + 1) && 32'(len) <= 32'(TAG_MAX);
  wire chk_drop   = (st == ST_CHK) && (ovf || band_drop);
  wire out_fire   = out_valid && out_ready;
  wire send_end   = out_fire && out_last;
  wire release_h  = chk_drop || send_end;

  assign in_ready = (st == ST_FILL) && (!tx_en || hdr_valid);

  ckins_hdr u_hdr (
    .clk(clk), .rst_n(rst_n),
    .ctl_valid(ctl_valid), .ctl_data(ctl_data), .ctl_last(ctl_last),
    .ctl_ready(ctl_ready), .release_i(release_h),
    .hdr_o(hdr), .hdr_valid_o(hdr_valid), .err_o(ctl_err)
  );

  ckins_sum #(.LW(LW)) u_sum (
    .clk(clk), .rst_n(rst_n), .clr(release_h),
    .add_en(byte_store && room), .pos(len), .data(in_data),
    .start_off(hdr.start_off), .seed(hdr.seed), .csum_o(csum_now)
  );

  ckins_store #(.DEPTH(BUF_BYTES), .AW(AW)) u_store (
    .clk(clk), .we(byte_store && room), .waddr(len[AW-1:0]), .wdata(in_data),
    .raddr(rd[AW-1:0]), .rdata(mem_q)
  );

  // Insertion select on the replay path
  wire [16:0] rd_x   = 17'(rd);
  wire [16:0] wo_x   = {1'b0, hdr.wr_off};
  wire        put_hi = hdr.ins_en && (rd_x == wo_x);
  wire        put_lo = hdr.ins_en && (rd_x == wo_x + 17'd1);

  assign out_valid  = (st == ST_DRAIN);
  assign out_last   = (st == ST_DRAIN) && (rd == len - LW'(1));
  assign out_data   = put_hi ? csum_q[15:8] : (put_lo ? csum_q[7:0] : mem_q);
  assign tx_done    = done_q;
  assign ovf_err    = ovf_q;
  assign byte_count = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_FILL;
      len    <= '0;
      rd     <= '0;
      ovf    <= 1'b0;
      csum_q <= '0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      case (st)
        ST_FILL: begin
          if (byte_store) begin
            if (room) len <= len + LW'(1);
            else      ovf <= 1'b1;
          end
          if (frame_end) st <= ST_CHK;
        end
        ST_CHK: begin
          csum_q <= csum_now;
          if (chk_drop) begin
            ovf_q <= ovf;
            st    <= ST_FILL;
          end else begin
            st <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (out_fire) rd <= rd + LW'(1);
          if (send_end) begin
            done_q <= 1'b1;
            cnt_q  <= cnt_q + CNT_W'(len);
            st     <= ST_FILL;
          end
        end
        default: st <= ST_FILL;
      endcase
      if (release_h) begin
        len <= '0;
        rd  <= '0;
        ovf <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ckins_chk.sv
module ckins_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_last,
  input logic             ctl_ready,
  input logic             tx_done,
  input logic             ovf_err,
  input logic [CNT_W-1:0] byte_count
);
  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $past(out_valid && out_ready && out_last));

  assert_count_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_done |-> $stable(byte_count));

  assert_count_grows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (byte_count > $past(byte_count)));

  assert_hdr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !ctl_ready);

  assert_ovf_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> (!out_valid && ctl_ready && !tx_done));
endmodule

bind tx_csum_insert ckins_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .ctl_ready(ctl_ready),
  .tx_done(tx_done), .ovf_err(ovf_err), .byte_count(byte_count)
);

// File: tb/tx_csum_insert_bench.sv
`timescale 1ns/1ps
module tx_csum_insert_bench;
  localparam int BUF = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b1, jumbo_en = 1'b0, vlan_en = 1'b0;
  logic        ctl_valid = 1'b0, ctl_last = 1'b0;
  logic [31:0] ctl_data = '0;
  logic        ctl_ready;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        out_valid, out_last;
  logic [7:0]  out_data;
  logic        out_ready = 1'b0;
  logic        tx_done, ovf_err, ctl_err;
  logic [63:0] byte_count;

  always #2 clk = ~clk;

  tx_csum_insert #(.BUF_BYTES(BUF), .CNT_W(64)) u_tx_csum_insert (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .jumbo_en(jumbo_en), .vlan_en(vlan_en),
    .ctl_valid(ctl_valid), .ctl_data(ctl_data), .ctl_last(ctl_last), .ctl_ready(ctl_ready),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
    .tx_done(tx_done), .ovf_err(ovf_err), .ctl_err(ctl_err), .byte_count(byte_count)
  );

  int checks = 0;
  int fails = 0;
  longint exp_cnt = 0;
  logic [7:0] fr [0:2100];
  logic [7:0] ex [0:2100];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Independent model: pairwise big-endian terms, loop fold, invert.
  function automatic logic [15:0] model_csum(int n, int st, int seed);
    longint s = 0;
    for (int i = st; i < n; i += 2) begin
      s += (longint'(fr[i]) << 8) + ((i + 1 < n) ? longint'(fr[i+1]) : 0);
    end
    s += seed;
    while (s > 64'hFFFF) s = (s & 64'hFFFF) + (s >> 16);
    return ~s[15:0];
  endfunction

  task automatic send_hdr(input int nw, input bit en, input int st, input int wo, input int seed);
    for (int i = 0; i < nw; i++) begin
      ctl_valid = 1'b1;
      ctl_last  = (i == nw - 1);
      case (i)
        0: ctl_data = {$urandom() >> 1, en};
        1: ctl_data = {st[15:0], wo[15:0]};
        2: ctl_data = {$urandom() >> 16, seed[15:0]};
        default: ctl_data = $urandom();
      endcase
      while (!ctl_ready) @(negedge clk);
      @(negedge clk);
    end
    ctl_valid = 1'b0;
    ctl_last  = 1'b0;
  endtask

  task automatic push_frame(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = fr[i];
      in_last  = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic fill_random(input int n);
    for (int i = 0; i < n; i++) fr[i] = 8'($urandom());
  endtask

  task automatic recv_check(input int n, input bit en, input int st, input int wo,
                            input int seed, input string req);
    logic [15:0] c;
    int got = 0;
    int bad = 0;
    int first_bad = -1;
    int tmo = 0;
    bit seen_last = 0;
    c = model_csum(n, st, seed);
    for (int i = 0; i < n; i++) ex[i] = fr[i];
    if (en) begin
      if (wo < n)     ex[wo]   = c[15:8];
      if (wo + 1 < n) ex[wo+1] = c[7:0];
    end
    while (!seen_last && tmo < 8 * n + 200) begin
      out_ready = ($urandom() % 4) != 0;
      if (out_valid && out_ready) begin
        if (got < n && out_data !== ex[got]) begin
          bad++;
          if (first_bad < 0) first_bad = got;
        end
        if (out_last) seen_last = 1;
        got++;
      end
      @(negedge clk);
      tmo++;
    end
    out_ready = 1'b0;
    chk(got == n, req, "output length", got, n);
    chk(bad == 0, req, "byte mismatch at index",
        first_bad, first_bad < 0 ? 0 : ex[first_bad]);
    // R10: done pulse in the cycle after the last handshake
    chk(tx_done === 1'b1, "R10", "tx_done after last byte", tx_done, 1);
    exp_cnt += n;
    @(negedge clk);
    chk(tx_done === 1'b0, "R10", "tx_done single cycle", tx_done, 0);
    chk(byte_count == 64'(exp_cnt), "R10", "byte_count", byte_count, exp_cnt);
  endtask

  task automatic expect_silent(input int cyc, input string req, output bit ovf_seen);
    bit any = 0;
    ovf_seen = 0;
    for (int i = 0; i < cyc; i++) begin
      if (out_valid || tx_done) any = 1;
      if (ovf_err) ovf_seen = 1;
      @(negedge clk);
    end
    chk(!any, req, "no output for dropped/discarded data", any, 0);
  endtask

  task automatic frame(input int n, input bit en, input int st, input int wo,
                       input int seed, input string req);
    send_hdr(5, en, st, wo, seed);
    push_frame(n);
    recv_check(n, en, st, wo, seed, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit ov;
    bit es;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(out_valid === 1'b0 && tx_done === 1'b0 && ovf_err === 1'b0 && ctl_err === 1'b0,
        "R1", "idle outputs", {out_valid, tx_done, ovf_err, ctl_err}, 0);
    chk(ctl_ready === 1'b1, "R1", "ctl_ready", ctl_ready, 1);
    chk(byte_count == 0, "R1", "byte_count", byte_count, 0);
    chk(in_ready === 1'b0, "R1", "in_ready without record", in_ready, 0);

    // R3 R4 R5: directed, even and odd start, odd length
    for (int i = 0; i < 20; i++) fr[i] = 8'(i * 7 + 3);
    fr[16] = 8'h00; fr[17] = 8'h00;
    frame(20, 1'b1, 14, 16, 0, "R3/R5 directed");
    fill_random(33);
    frame(33, 1'b1, 5, 9, 16'h1234, "R3/R4 odd start odd length");
    // R4: all-ones sum -> 0x0000 result
    for (int i = 0; i < 4; i++) fr[i] = 8'h00;
    fr[2] = 8'hFF; fr[3] = 8'hFE;
    frame(4, 1'b1, 2, 0, 16'h0001, "R4 folded ffff");
    // R5: write offset at last byte and beyond frame
    fill_random(12);
    frame(12, 1'b1, 0, 11, 16'hBEEF, "R5 partial insert");
    fill_random(12);
    frame(12, 1'b1, 0, 40, 16'h0F0F, "R5 offset outside");
    // R6
    fill_random(25);
    frame(25, 1'b0, 0, 4, 16'h5555, "R6 passthrough");

    // R2: short and long records rejected
    send_hdr(4, 1'b1, 0, 0, 0);
    es = 0;
    for (int i = 0; i < 3; i++) begin if (ctl_err) es = 1; @(negedge clk); end
    chk(es, "R2", "ctl_err on 4-word record", es, 1);
    chk(ctl_ready === 1'b1 && in_ready === 1'b0, "R2", "short record not held",
        {ctl_ready, in_ready}, 2'b10);
    send_hdr(6, 1'b1, 0, 0, 0);
    es = 0;
    for (int i = 0; i < 3; i++) begin if (ctl_err) es = 1; @(negedge clk); end
    chk(es, "R2", "ctl_err on 6-word record", es, 1);
    chk(ctl_ready === 1'b1, "R2", "long record not held", ctl_ready, 1);

    // R7: disabled transmitter discards bytes, record stays held
    tx_en = 1'b0;
    send_hdr(5, 1'b1, 2, 3, 16'h0102);
    fill_random(10);
    push_frame(10);
    expect_silent(20, "R7", ov);
    chk(ctl_ready === 1'b0, "R7", "record held while disabled", ctl_ready, 0);
    tx_en = 1'b1;
    fill_random(8);
    push_frame(8);
    recv_check(8, 1'b1, 2, 3, 16'h0102, "R7 after enable");

    // R8: exact capacity passes, one more byte drops with error
    jumbo_en = 1'b1;
    fill_random(BUF);
    frame(BUF, 1'b1, 100, 2000, 16'h4321, "R8 exact capacity");
    send_hdr(5, 1'b1, 0, 0, 0);
    fill_random(BUF + 1);
    push_frame(BUF + 1);
    expect_silent(6, "R8", ov);
    chk(ov, "R8", "ovf_err on oversize", ov, 1);
    chk(ctl_ready === 1'b1, "R8", "record released after drop", ctl_ready, 1);
    chk(byte_count == 64'(exp_cnt), "R8", "byte_count unchanged", byte_count, exp_cnt);
    fill_random(16);
    frame(16, 1'b1, 0, 0, 0, "R8 recovery");

    // R9: length band rule
    jumbo_en = 1'b0; vlan_en = 1'b0;
    send_hdr(5, 1'b1, 0, 0, 0);
    fill_random(1520);
    push_frame(1520);
    expect_silent(6, "R9", ov);
    chk(!ov && ctl_ready === 1'b1, "R9", "silent drop of 1520", {ov, ctl_ready}, 1);
    send_hdr(5, 1'b1, 0, 0, 0);
    fill_random(1522);
    push_frame(1522);
    expect_silent(6, "R9", ov);
    fill_random(1518);
    frame(1518, 1'b1, 14, 30, 16'h0, "R9 standard max");
    vlan_en = 1'b1;
    fill_random(1520);
    frame(1520, 1'b1, 14, 30, 16'h0, "R9 tagged allowed");
    vlan_en = 1'b0;
    fill_random(1523);
    frame(1523, 1'b1, 0, 1, 16'h0, "R9 above band");

    // Random mix (R3 R4 R5 R6 R11 via stalls)
    for (int k = 0; k < 30; k++) begin
      int n, st, wo, sd;
      bit en;
      n  = 1 + int'($urandom() % 200);
      st = int'($urandom() % (n + 2));
      wo = int'($urandom() % (n + 1));
      sd = int'($urandom() & 32'hFFFF);
      en = ($urandom() % 4) != 0;
      fill_random(n);
      frame(n, en, st, wo, sd, "R3/R5 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule